// File: doc/BRIEF.md
# Protocol Response Packet Generator

This block turns one response request from the device core into a complete reply frame. It emits the frame one byte at a time on a valid/ready stream. The request names the reply kind, the register address, a word count, a hidden-register flag and an error class. The block then sends three fixed sync bytes, a type byte, the address byte, an optional data section and a 16-bit checksum.

Three reply kinds are supported:

- A read reply fetches register words through a simple combinational word-read port and sends each word most significant byte first.
- An acknowledgement echoes only the address, with a type byte of zero.
- An error reply keeps the acknowledgement header but sets the error bit and has-data. It carries a one-word payload spelling the ASCII error code.

The core must not present a new request while a frame is in flight. The block holds its request-ready low from the moment it accepts a request until the downstream side has taken the last checksum byte.

Top module: `rsp_packet_gen`

## Requirements
- R1: After reset, reqReady is 1 and outValid is 0.
- R2: When a request is accepted (reqValid and reqReady high at a clock edge), the cycle after shows reqReady 0 and outValid 1. reqReady stays 0 until the last checksum byte is accepted, and reads 1 with outValid 0 in the cycle after that.
- R3: While outValid is 1 and outReady is 0, outValid stays 1 and outData keeps its value on the next cycle.
- R4: Every frame is sent in this order:
  - the sync bytes 0x73, 0x6E, 0x70;
  - the type byte;
  - the address byte;
  - the data section of 4·n bytes;
  - the two checksum bytes.

  Total length is 7 + 4·n bytes, where n is the number of payload words.
- R5: A read reply (reqKind = 0) has a type byte with bit 7 = 1, bits 6:2 = reqWords, bit 1 = reqHidden and bit 0 = 0. It carries n = reqWords words. Word i is taken from rdData while rdAddr = reqAddr + i (modulo 2^ADDR_W), and is sent most significant byte first.
- R6: An acknowledgement (reqKind = 1, and also reqKind = 3) has type byte 0x00 whatever reqHidden and reqWords are. It echoes reqAddr and carries no data (7 bytes).
- R7: An error reply (reqKind = 2) has type byte 0x85 (has-data, length 1, error bit), whatever reqHidden is. Its payload is 0x45 ('E'), 0x30, 0x30, then 0x30 + reqErrClass. Class 1 gives "E001" (invalid address), class 2 gives "E002" (bad checksum) and class 3 gives "E003" (bad structure).
- R8: The two closing bytes are the unsigned 16-bit sum of every earlier byte of the frame, sync bytes included. The high byte is sent first.
- R9: A read reply of the largest count (31 words) is sent in full (131 bytes). When the address range passes the top of the address space, the word addresses wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Response request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqKind | input | 2 | 0 read reply, 1 or 3 acknowledgement, 2 error reply |
| reqAddr | input | ADDR_W | Register (start) address echoed in the frame |
| reqWords | input | LEN_W | Word count for a read reply |
| reqHidden | input | 1 | Hidden-register flag for a read reply |
| reqErrClass | input | 2 | Error class for an error reply |
| rdAddr | output | ADDR_W | Word-read address |
| rdData | input | DATA_W | Word-read data, combinational from rdAddr |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream takes the byte |
| outData | output | 8 | Output byte |

## Verification
The bench uses the default parameters: an 8-bit address, 32-bit words and a 5-bit count field. The 5-bit count allows the longest 131-byte read reply. The 8-bit address makes a batch starting near the top of the address space wrap within a single frame. The downstream ready is driven either constantly high or from a pseudo-random sequence. This exercises back-to-back frames as well as stalls on sync, data and checksum bytes.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  typedef enum logic [1:0] {
    KIND_READ = 2'd0,
    KIND_ACK  = 2'd1,
    KIND_ERR  = 2'd2,
    KIND_ACK2 = 2'd3
  } rsp_kind_e;

  // Which byte of the frame is currently held (or is to be loaded).
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SYNC0,
    PH_SYNC1,
    PH_SYNC2,
    PH_TYPE,
    PH_ADDR,
    PH_DATA,
    PH_SUMH,
    PH_SUML
  } phase_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   capture;   // latch request, preload first sync byte
    logic   load;      // load output register with byte chosen by sel
    logic   stepData;  // advance payload byte/word counters
    phase_e sel;
  } ctrl_t;

endpackage

// File: rtl/rsp_ctrl.sv
module rsp_ctrl
  import rsp_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  input  logic  outReady,
  input  logic  allLoaded,
  output logic  reqReady,
  output logic  outValid,
  output ctrl_t ctrl
);

  phase_e state, nextState, follow;

  // Phase that follows the one now on the output.
  always_comb begin
    case (state)
      PH_SYNC0: follow = PH_SYNC1;
      PH_SYNC1: follow = PH_SYNC2;
      PH_SYNC2: follow = PH_TYPE;
      PH_TYPE:  follow = PH_ADDR;
      PH_ADDR,
      PH_DATA:  follow = allLoaded ? PH_SUMH : PH_DATA;
      PH_SUMH:  follow = PH_SUML;
      default:  follow = PH_IDLE;
    endcase
  end

  always_comb begin
    nextState     = state;
    ctrl.capture  = 1'b0;
    ctrl.load     = 1'b0;
    ctrl.stepData = 1'b0;
    ctrl.sel      = PH_IDLE;
    if (state == PH_IDLE) begin
      if (reqValid) begin
        ctrl.capture = 1'b1;
        nextState    = PH_SYNC0;
      end
    end else if (outReady) begin
      nextState = follow;
      if (follow != PH_IDLE) begin
        ctrl.load     = 1'b1;
        ctrl.sel      = follow;
        ctrl.stepData = (follow == PH_DATA);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == PH_IDLE);
  assign outValid = (state != PH_IDLE);

endmodule

// File: rtl/rsp_datapath.sv
module rsp_datapath
  import rsp_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter int         DATA_W = 32,
  parameter int         LEN_W  = 5,
  parameter logic [7:0] SYNC0  = 8'h73,
  parameter logic [7:0] SYNC1  = 8'h6E,
  parameter logic [7:0] SYNC2  = 8'h70
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqWords,
  input  logic              reqHidden,
  input  logic [1:0]        reqErrClass,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [7:0]        outData,
  output logic              allLoaded
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BIDX_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam int WIDX_W     = LEN_W + 1;
  localparam int SUM_W      = 16;
  localparam logic [7:0] ASCII_E    = 8'h45;
  localparam logic [7:0] ASCII_ZERO = 8'h30;
  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(WORD_BYTES - 1);

  rsp_kind_e         kindQ;
  logic [ADDR_W-1:0] addrQ;
  logic [LEN_W-1:0]  wordsQ;
  logic              hiddenQ;
  logic [1:0]        errClsQ;
  logic [BIDX_W-1:0] byteIdx;
  logic [WIDX_W-1:0] wordIdx;
  logic [7:0]        outByte;
  logic [SUM_W-1:0]  sum;

  logic [WIDX_W-1:0] nWords;
  logic [7:0]        typeByte;
  logic [7:0]        dataByte;
  logic [7:0]        nextByte;
  logic [DATA_W-1:0] shifted;

  // Payload word count and type byte per reply kind.
  always_comb begin
    case (kindQ)
      KIND_READ: begin
        nWords   = {1'b0, wordsQ};
        typeByte = 8'({1'b1, wordsQ, hiddenQ, 1'b0});
      end
      KIND_ERR: begin
        nWords   = WIDX_W'(1);
        typeByte = 8'({1'b1, LEN_W'(1), 1'b0, 1'b1});
      end
      default: begin
        nWords   = '0;
        typeByte = 8'h00;
      end
    endcase
  end

  assign allLoaded = (wordIdx == nWords);
  assign rdAddr    = addrQ + ADDR_W'(wordIdx);
  assign shifted   = rdData << (8 * byteIdx);

  always_comb begin
    if (kindQ == KIND_ERR) begin
      case (byteIdx)
        BIDX_W'(0): dataByte = ASCII_E;
        LAST_BYTE:  dataByte = ASCII_ZERO + {6'd0, errClsQ};
        default:    dataByte = ASCII_ZERO;
      endcase
    end else begin
      dataByte = shifted[DATA_W-1 -: 8];
    end
  end

  always_comb begin
    case (ctrl.sel)
      PH_SYNC0: nextByte = SYNC0;
      PH_SYNC1: nextByte = SYNC1;
      PH_SYNC2: nextByte = SYNC2;
      PH_TYPE:  nextByte = typeByte;
      PH_ADDR:  nextByte = 8'(addrQ);
      PH_DATA:  nextByte = dataByte;
      PH_SUMH:  nextByte = sum[15:8];
      PH_SUML:  nextByte = sum[7:0];
      default:  nextByte = outByte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ   <= KIND_ACK;
      addrQ   <= '0;
      wordsQ  <= '0;
      hiddenQ <= 1'b0;
      errClsQ <= '0;
      byteIdx <= '0;
      wordIdx <= '0;
      outByte <= '0;
      sum     <= '0;
    end else if (ctrl.capture) begin
      kindQ   <= rsp_kind_e'(reqKind);
      addrQ   <= reqAddr;
      wordsQ  <= reqWords;
      hiddenQ <= reqHidden;
      errClsQ <= reqErrClass;
      byteIdx <= '0;
      wordIdx <= '0;
      outByte <= SYNC0;
      sum     <= SUM_W'(SYNC0);
    end else begin
      if (ctrl.load) begin
        outByte <= nextByte;
        if (ctrl.sel != PH_SUMH && ctrl.sel != PH_SUML)
          sum <= sum + SUM_W'(nextByte);
      end
      if (ctrl.stepData) begin
        byteIdx <= byteIdx + 1'b1;
        if (byteIdx == LAST_BYTE) begin
          byteIdx <= '0;
          wordIdx <= wordIdx + 1'b1;
        end
      end
    end
  end

  assign outData = outByte;

endmodule

// File: rtl/rsp_packet_gen.sv
module rsp_packet_gen
  import rsp_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter int         DATA_W = 32,
  parameter int         LEN_W  = 5,
  parameter logic [7:0] SYNC0  = 8'h73,
  parameter logic [7:0] SYNC1  = 8'h6E,
  parameter logic [7:0] SYNC2  = 8'h70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqWords,
  input  logic              reqHidden,
  input  logic [1:0]        reqErrClass,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData
);

  ctrl_t ctrl;
  logic  allLoaded;

  rsp_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .outReady  (outReady),
    .allLoaded (allLoaded),
    .reqReady  (reqReady),
    .outValid  (outValid),
    .ctrl      (ctrl)
  );

  rsp_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .SYNC0  (SYNC0),
    .SYNC1  (SYNC1),
    .SYNC2  (SYNC2)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .reqKind     (reqKind),
    .reqAddr     (reqAddr),
    .reqWords    (reqWords),
    .reqHidden   (reqHidden),
    .reqErrClass (reqErrClass),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .outData     (outData),
    .allLoaded   (allLoaded)
  );

endmodule

// File: rtl/rsp_packet_gen_chk.sv
module rsp_packet_gen_chk #(
  parameter int         LEN_W = 5,
  parameter logic [7:0] SYNC0 = 8'h73
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [1:0]       reqKind,
  input logic [LEN_W-1:0] reqWords,
  input logic             outValid,
  input logic             outReady,
  input logic [7:0]       outData
);

  localparam int POS_W = LEN_W + 4;

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] lenC;
  logic [15:0]      sumC;

  // Independent frame tracker: length from the request, sum of bytes seen.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos  <= '0;
      lenC <= POS_W'(7);
      sumC <= '0;
    end else if (reqValid && reqReady) begin
      pos  <= '0;
      sumC <= '0;
      case (reqKind)
        2'd0:    lenC <= POS_W'(7) + (POS_W'(reqWords) << 2);
        2'd2:    lenC <= POS_W'(11);
        default: lenC <= POS_W'(7);
      endcase
    end else if (outValid && outReady) begin
      pos <= pos + 1'b1;
      if (pos < lenC - POS_W'(2))
        sumC <= sumC + {8'd0, outData};
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && outValid));

  assert_ready_after_last_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && pos == lenC - POS_W'(1)) |=> (reqReady && !outValid));

  assert_first_sync_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pos == '0) |-> (outData == SYNC0));

  assert_frame_length_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (pos < lenC));

  assert_sum_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pos == lenC - POS_W'(2)) |-> (outData == sumC[15:8]));

  assert_sum_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pos == lenC - POS_W'(1)) |-> (outData == sumC[7:0]));

endmodule

bind rsp_packet_gen rsp_packet_gen_chk #(
  .LEN_W (LEN_W),
  .SYNC0 (SYNC0)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqKind  (reqKind),
  .reqWords (reqWords),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/rsp_packet_gen_tb_top.sv
module rsp_packet_gen_tb_top;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 5;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic              reqReady;
  logic [1:0]        reqKind;
  logic [ADDR_W-1:0] reqAddr;
  logic [LEN_W-1:0]  reqWords;
  logic              reqHidden;
  logic [1:0]        reqErrClass;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData;
  logic              outValid;
  logic              outReady;
  logic [7:0]        outData;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] memWord(input logic [7:0] a);
    return {a ^ 8'hA5, a + 8'h3C, ~a, a};
  endfunction

  assign rdData = memWord(rdAddr);

  rsp_packet_gen dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .reqKind     (reqKind),
    .reqAddr     (reqAddr),
    .reqWords    (reqWords),
    .reqHidden   (reqHidden),
    .reqErrClass (reqErrClass),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .outValid    (outValid),
    .outReady    (outReady),
    .outData     (outData)
  );

  // Scoreboard
  logic [7:0] expQ[$];
  string      tagQ[$];
  bit         lastQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic pushExp(input logic [7:0] b, input string tag, input bit last);
    expQ.push_back(b);
    tagQ.push_back(tag);
    lastQ.push_back(last);
  endtask

  // Driver: builds the expected frame from the requirements, then issues it.
  task automatic sendReq(input logic [1:0] k, input logic [7:0] a, input logic [4:0] w,
                         input bit h, input logic [1:0] c, input string tag);
    logic [7:0]  fr[$];
    logic [15:0] s;
    logic [31:0] wd;
    fr.push_back(8'h73); fr.push_back(8'h6E); fr.push_back(8'h70);   // R4 sync
    case (k)
      2'd0: begin                                                    // R5
        fr.push_back({1'b1, w, h, 1'b0});
        fr.push_back(a);
        for (int i = 0; i < int'(w); i++) begin
          wd = memWord(a + 8'(i));                                   // R9 wraps
          for (int j = 3; j >= 0; j--) fr.push_back(wd[8*j +: 8]);
        end
      end
      2'd2: begin                                                    // R7
        fr.push_back(8'h85);
        fr.push_back(a);
        fr.push_back(8'h45); fr.push_back(8'h30); fr.push_back(8'h30);
        fr.push_back(8'h30 + {6'd0, c});
      end
      default: begin                                                 // R6
        fr.push_back(8'h00);
        fr.push_back(a);
      end
    endcase
    s = '0;
    foreach (fr[i]) s = s + {8'd0, fr[i]};                           // R8
    foreach (fr[i]) pushExp(fr[i], tag, 1'b0);
    pushExp(s[15:8], {tag, " R8 sumH"}, 1'b0);
    pushExp(s[7:0],  {tag, " R8 sumL"}, 1'b1);

    @(posedge clk); #1;
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqWords = w;
    reqHidden = h; reqErrClass = c;
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #1;
    reqValid = 1'b0;
    reqKind = 2'd0; reqWords = 5'd31; reqHidden = 1'b1; reqErrClass = 2'd0;
    @(negedge clk);
    check(!reqReady && outValid, {tag, " R2 busy after accept"},
          {reqReady, outValid}, 2'b01);
  endtask

  // Monitor
  bit         holdPrev = 1'b0;
  logic [7:0] dataPrev;
  bit         readyDue = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (readyDue) begin
        check(reqReady && !outValid, "R2 ready after last byte",
              {reqReady, outValid}, 2'b10);
        readyDue = 1'b0;
      end
      if (holdPrev)
        check(outValid && outData == dataPrev, "R3 hold under stall",
              outData, dataPrev);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected byte", outData, 0);
        end else begin
          logic [7:0] e;
          string t;
          bit l;
          e = expQ.pop_front(); t = tagQ.pop_front(); l = lastQ.pop_front();
          check(outData == e, t, outData, e);
          if (l) readyDue = 1'b1;
        end
      end
      holdPrev = outValid && !outReady;
      dataPrev = outData;
    end
  end

  // Downstream ready: constant or pseudo-random stall pattern.
  bit         stallMode = 1'b0;
  logic [7:0] lfsr = 8'hB7;

  always @(posedge clk) begin
    #1;
    lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady = stallMode ? lfsr[0] : 1'b1;
  end

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqKind = '0; reqAddr = '0; reqWords = '0;
    reqHidden = 1'b0; reqErrClass = '0; outReady = 1'b1;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !outValid, "R1 reset state", {reqReady, outValid}, 2'b10);

    // No stalls, back-to-back frames
    sendReq(2'd0, 8'h10, 5'd1, 1'b0, 2'd0, "R5 read single");
    sendReq(2'd0, 8'h20, 5'd3, 1'b1, 2'd0, "R5 read batch hidden");
    sendReq(2'd1, 8'h42, 5'd7, 1'b1, 2'd2, "R6 ack ignores hidden/count");
    sendReq(2'd2, 8'h99, 5'd0, 1'b1, 2'd1, "R7 error E001");
    drain();

    // Random stalls
    stallMode = 1'b1;
    sendReq(2'd2, 8'h05, 5'd4, 1'b0, 2'd2, "R7 error E002");
    sendReq(2'd2, 8'hFF, 5'd0, 1'b0, 2'd3, "R7 error E003");
    sendReq(2'd3, 8'h7E, 5'd2, 1'b0, 2'd0, "R6 ack kind 3");
    sendReq(2'd0, 8'hF0, 5'd31, 1'b0, 2'd0, "R9 max batch with wrap");
    sendReq(2'd0, 8'h33, 5'd2, 1'b0, 2'd0, "R4 read under stalls");
    drain();
    stallMode = 1'b0;
    sendReq(2'd0, 8'hFE, 5'd5, 1'b1, 2'd0, "R9 wrap no stall");
    drain();

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule